// File: doc/BRIEF.md
# Interrupt Flag and Request Controller

This block keeps one latched interrupt flag for each of ten event sources: eight port inputs (source indices 0 to 7) and two key inputs (indices 8 and 9). A one-cycle trigger pulse on a source sets its flag. Only software clears a flag, through a byte-wide register port. A mode input chooses how writes act. In the default mode a written 1 clears a flag and a written 0 does nothing. In the other mode the flag simply takes the value written.

From the flags, a per-source enable, three group priority levels, the CPU's global interrupt enable and the CPU's current level, the block forms one CPU interrupt request. With the request it gives the identity and level of the winning source. A source can be steered to a DMA engine instead. Such a source then raises a DMA request, and it can only compete for the CPU after the engine signals that the transfer has finished.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A trigger pulse on source i makes flag i read as 1 from the next cycle on, whatever the enable, level, routing and CPU settings are.
- R2: Register 0 shows port flags 0..3 in bits [3:0] and key flags 0..1 in bits [5:4]. Register 1 shows port flags 4..7 in bits [5:2]. All other read bits are 0, and written values at unmapped bit positions have no effect.
- R3: With the write-mode input at 1, writing 1 to a mapped bit clears that flag and writing 0 leaves it unchanged.
- R4: With the write-mode input at 0, a write loads every mapped bit of the addressed register: 1 sets the flag and 0 clears it.
- R5: When a trigger and a software clear reach the same flag in the same cycle, the flag ends up set.
- R6: `irq_o` is 1 only if some flag is set with its enable at 1, is not held back by DMA routing, the global enable is 1, and the source's group level is strictly greater than `cpu_lvl_i`.
- R7: Among the qualifying sources, the highest group level wins and equal levels go to the lowest source index. `irq_id_o` and `irq_lvl_o` give the winner, and both are 0 when `irq_o` is 0. Group 0 is ports 0..3, group 1 is ports 4..7 and group 2 is the keys. Each group's level sits in `grp_lvl_i[3g+2:3g]`.
- R8: A set flag of a DMA-routed source drives its `dma_req_o` bit and raises no CPU request. After a `dma_done_i` pulse for that source, the DMA request drops and the source competes for the CPU from the next cycle on, provided it is enabled.
- R9: Hardware never clears a flag. A set flag keeps its request asserted until software clears it.
- R10: After reset every flag is 0, and `irq_o` and `dma_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 10 | One-cycle set pulses: bits 0..7 ports, bits 8..9 keys |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| wr_addr_i | input | 1 | Write register select (0 or 1) |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 1 | Read register select (0 or 1) |
| rd_data_o | output | 8 | Combinational read data |
| rst_only_i | input | 1 | Write mode: 1 write-one-to-clear, 0 plain load |
| src_en_i | input | 10 | Per-source interrupt enable |
| grp_lvl_i | input | 9 | Three 3-bit group levels: ports 0..3, ports 4..7, keys |
| dma_route_i | input | 10 | Per-source steering to DMA |
| dma_done_i | input | 10 | Per-source DMA transfer-complete pulse |
| cpu_ie_i | input | 1 | CPU global interrupt enable |
| cpu_lvl_i | input | 3 | CPU current interrupt level |
| irq_o | output | 1 | CPU interrupt request |
| irq_id_o | output | 4 | Index of the winning source |
| irq_lvl_o | output | 3 | Level of the winning source |
| dma_req_o | output | 10 | Per-source DMA request |

## Verification
A hardware set and a software write can land on the same flag in the same cycle. The stimulus table has rows that pulse a source's trigger while the same strobe clears that bit, once in each write mode. The flag must read back as 1 in the cycle after the write, and the neighbouring bits of the same write must follow the mode's rule. A second overlap comes from the DMA path: the transfer-complete pulse and the CPU arbitration. The bench checks that the request moves from `dma_req_o` to `irq_o` in exactly one cycle, with the right identity and level.

// File: rtl/irqf_pkg.sv
// Package: shared layout constants and source-to-register mapping for
// the interrupt flag controller. Assumes at most 8 port and 2 key sources.
package irqf_pkg;
    localparam int DATA_W       = 8;  // register width
    localparam int ADDR_W       = 1;  // two flag registers
    localparam int LO_PORTS     = 4;  // ports shown in register 0
    localparam int HI_PORT_BIT0 = 2;  // first bit of upper ports in register 1
    localparam int KEY_BIT0     = 4;  // first key bit in register 0
    localparam int NGRP         = 3;  // level groups: low ports, high ports, keys

    // Register index holding source i (ports first, then keys).
    function automatic int src_reg(int i, int np);
        return (i < LO_PORTS || i >= np) ? 0 : 1;
    endfunction

    // Bit position of source i inside its register.
    function automatic int src_bit(int i, int np);
        if (i < LO_PORTS) return i;
        if (i < np)       return i - LO_PORTS + HI_PORT_BIT0;
        return KEY_BIT0 + (i - np);
    endfunction

    // Level group of source i.
    function automatic int src_grp(int i, int np);
        if (i < LO_PORTS) return 0;
        if (i < np)       return 1;
        return 2;
    endfunction
endpackage

// File: rtl/irqf_flag_bank.sv
// Flag bank: one flag per source, set by trigger pulses, written by
// software under one of two conventions, read back combinationally.
// Assumes triggers are one-cycle pulses; a set beats a clear.
module irqf_flag_bank
    import irqf_pkg::*;
#(
    parameter int NUM_PORT = 8,
    parameter int NSRC     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   trig,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rst_only,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NSRC-1:0]   flag
);
    logic [NSRC-1:0]   flag_q;
    logic [NSRC-1:0]   sw_next;
    logic [NSRC-1:0]   flag_d;
    logic [DATA_W-1:0] rd_part [NSRC];
    logic              unused_wr_bits;

    // Mark write data as consumed; unmapped bits are ignored by design.
    assign unused_wr_bits = ^wr_data;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        localparam int REG_IDX = src_reg(i, NUM_PORT);
        localparam int BIT_IDX = src_bit(i, NUM_PORT);
        logic hit;
        logic val;

        // Decode whether this write touches source i, and its bit value.
        assign hit = wr_en && (int'(wr_addr) == REG_IDX);
        assign val = wr_data[BIT_IDX];

        // Apply the selected write convention to this flag.
        always_comb begin
            if (!hit)          sw_next[i] = flag_q[i];
            else if (rst_only) sw_next[i] = flag_q[i] & ~val;
            else               sw_next[i] = val;
        end

        // Place the flag at its read position when its register is addressed.
        assign rd_part[i] = (int'(rd_addr) == REG_IDX)
                          ? (DATA_W'(flag_q[i]) << BIT_IDX) : '0;
    end

    // Trigger set overrides any software clear in the same cycle.
    assign flag_d = sw_next | trig;

    // Flag register with synchronous reset to cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    // Merge the per-source read contributions.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NSRC; i++) rd_data = rd_data | rd_part[i];
    end

    assign flag = flag_q;

    // A trigger always leaves its flag set on the next cycle.
    assert_trig_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (trig != '0) |=> ((flag_q & $past(trig)) == $past(trig)));

    // With no write strobe, no flag falls.
    assert_hw_never_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (($past(flag_q) & ~flag_q) == '0));

    // In reset-only mode a write never raises a flag by itself.
    assert_ro_no_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rst_only && trig == '0) |=> ((flag_q & ~$past(flag_q)) == '0));
endmodule

// File: rtl/irqf_dma_gate.sv
// DMA gate: for sources steered to DMA, drives a DMA request while the
// flag is set and the transfer is pending, and releases the source to
// CPU arbitration once the completion pulse has been seen.
// Assumes the completion pulse is one cycle long.
module irqf_dma_gate #(
    parameter int NSRC = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] flag,
    input  logic [NSRC-1:0] trig,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] route,
    input  logic [NSRC-1:0] dma_done,
    output logic [NSRC-1:0] dma_req,
    output logic [NSRC-1:0] elig
);
    logic [NSRC-1:0] done_q;

    // Remember completed transfers; a new trigger or a cleared flag forgets.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= '0;
        else        done_q <= (done_q | (dma_done & route & flag)) & ~trig & flag;
    end

    // Pending transfer request per routed source.
    assign dma_req = flag & route & ~done_q;

    // A source may compete for the CPU when enabled and not awaiting DMA.
    assign elig = flag & src_en & (~route | done_q);

    // A freshly triggered routed source cannot compete on the next cycle.
    assert_dma_holds_cpu_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig & route) != '0) |=> ((elig & $past(trig & route)) == '0));
endmodule

// File: rtl/irqf_arbiter.sv
// Arbiter: picks the eligible source with the highest level, breaking
// ties toward the lowest index. Purely combinational.
module irqf_arbiter #(
    parameter int NSRC  = 10,
    parameter int LVL_W = 3,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  elig,
    input  logic [LVL_W-1:0] lvl [NSRC],
    output logic             found,
    output logic [ID_W-1:0]  best_id,
    output logic [LVL_W-1:0] best_lvl
);
    // Scan upward; only a strictly higher level replaces the holder.
    always_comb begin
        found    = 1'b0;
        best_id  = '0;
        best_lvl = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!found || lvl[i] > best_lvl)) begin
                found    = 1'b1;
                best_id  = ID_W'(i);
                best_lvl = lvl[i];
            end
        end
    end

    // The winner is always an eligible source carrying the reported level.
    assert_pick_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (elig[best_id] && lvl[best_id] == best_lvl));

    // Nothing is reported when nothing is eligible.
    assert_none_found_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |-> !found);
endmodule

// File: rtl/irq_flag_ctrl.sv
// Top: interrupt flag and request controller. Holds per-source flags,
// applies DMA steering, arbitrates by group level and gates the result
// with the CPU enable and level. Assumes configuration inputs are static
// relative to each request they shape.
module irq_flag_ctrl
    import irqf_pkg::*;
#(
    parameter int NUM_PORT = 8,
    parameter int NUM_KEY  = 2,
    parameter int LVL_W    = 3,
    localparam int NSRC    = NUM_PORT + NUM_KEY,
    localparam int ID_W    = $clog2(NSRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       trig_i,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    output logic [DATA_W-1:0]     rd_data_o,
    input  logic                  rst_only_i,
    input  logic [NSRC-1:0]       src_en_i,
    input  logic [NGRP*LVL_W-1:0] grp_lvl_i,
    input  logic [NSRC-1:0]       dma_route_i,
    input  logic [NSRC-1:0]       dma_done_i,
    input  logic                  cpu_ie_i,
    input  logic [LVL_W-1:0]      cpu_lvl_i,
    output logic                  irq_o,
    output logic [ID_W-1:0]       irq_id_o,
    output logic [LVL_W-1:0]      irq_lvl_o,
    output logic [NSRC-1:0]       dma_req_o
);
    logic [NSRC-1:0]  flag;
    logic [NSRC-1:0]  elig;
    logic [LVL_W-1:0] src_lvl [NSRC];
    logic             found;
    logic [ID_W-1:0]  best_id;
    logic [LVL_W-1:0] best_lvl;

    irqf_flag_bank #(.NUM_PORT(NUM_PORT), .NSRC(NSRC)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig_i),
        .wr_en    (wr_en_i),
        .wr_addr  (wr_addr_i),
        .wr_data  (wr_data_i),
        .rst_only (rst_only_i),
        .rd_addr  (rd_addr_i),
        .rd_data  (rd_data_o),
        .flag     (flag)
    );

    irqf_dma_gate #(.NSRC(NSRC)) u_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag     (flag),
        .trig     (trig_i),
        .src_en   (src_en_i),
        .route    (dma_route_i),
        .dma_done (dma_done_i),
        .dma_req  (dma_req_o),
        .elig     (elig)
    );

    // Give every source the level of its group.
    for (genvar i = 0; i < NSRC; i++) begin : g_lvl
        localparam int GRP = src_grp(i, NUM_PORT);
        assign src_lvl[i] = grp_lvl_i[GRP*LVL_W +: LVL_W];
    end

    irqf_arbiter #(.NSRC(NSRC), .LVL_W(LVL_W), .ID_W(ID_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .elig     (elig),
        .lvl      (src_lvl),
        .found    (found),
        .best_id  (best_id),
        .best_lvl (best_lvl)
    );

    // Gate the winner with the CPU enable and strict level comparison.
    always_comb begin
        irq_o     = cpu_ie_i && found && (best_lvl > cpu_lvl_i);
        irq_id_o  = irq_o ? best_id  : '0;
        irq_lvl_o = irq_o ? best_lvl : '0;
    end

    // A request needs the global enable, an enabled source and a higher level.
    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cpu_ie_i && src_en_i[irq_id_o] && flag[irq_id_o]
                   && irq_lvl_o > cpu_lvl_i));

    // A source still waiting for its transfer never wins the CPU.
    assert_no_cpu_while_dma_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !dma_req_o[irq_id_o]);

    // Outputs are quiet in the first cycle after reset.
    assert_reset_quiet_R10: assert property (@(posedge clk)
        $rose(rst_n) |-> (!irq_o && dma_req_o == '0));
endmodule

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  trig;
    logic        wr_en;
    logic        wr_addr;
    logic [7:0]  wr_data;
    logic        rd_addr;
    logic [7:0]  rd_data;
    logic        rst_only;
    logic [9:0]  src_en;
    logic [8:0]  grp_lvl;
    logic [9:0]  route;
    logic [9:0]  dma_done;
    logic        cpu_ie;
    logic [2:0]  cpu_lvl;
    logic        irq;
    logic [3:0]  irq_id;
    logic [2:0]  irq_lvl;
    logic [9:0]  dma_req;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_flag_ctrl u_irq_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .rst_only_i(rst_only), .src_en_i(src_en),
        .grp_lvl_i(grp_lvl), .dma_route_i(route), .dma_done_i(dma_done),
        .cpu_ie_i(cpu_ie), .cpu_lvl_i(cpu_lvl), .irq_o(irq),
        .irq_id_o(irq_id), .irq_lvl_o(irq_lvl), .dma_req_o(dma_req)
    );

    typedef struct packed {
        logic [9:0] trg;
        logic       we;
        logic       wa;
        logic [7:0] wd;
        logic       mode;
        logic [7:0] e0;
        logic [7:0] e1;
    } vec_t;

    // Stimulus rows walked in order from all-clear flags; enables are off.
    localparam vec_t TBL [15] = '{
        '{10'h001, 1'b0, 1'b0, 8'h00, 1'b1, 8'h01, 8'h00},  // R1 port0
        '{10'h300, 1'b0, 1'b0, 8'h00, 1'b1, 8'h31, 8'h00},  // R1 keys
        '{10'h0F0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h31, 8'h3C},  // R2 upper ports
        '{10'h000, 1'b1, 1'b0, 8'h11, 1'b1, 8'h20, 8'h3C},  // R3 clear p0,k0
        '{10'h000, 1'b1, 1'b1, 8'h00, 1'b1, 8'h20, 8'h3C},  // R3 zero ignored
        '{10'h000, 1'b1, 1'b1, 8'h14, 1'b0, 8'h20, 8'h14},  // R4 load reg1
        '{10'h000, 1'b1, 1'b0, 8'h0A, 1'b0, 8'h0A, 8'h14},  // R4 load reg0
        '{10'h002, 1'b1, 1'b0, 8'h02, 1'b1, 8'h0A, 8'h14},  // R5 set beats w1c
        '{10'h020, 1'b1, 1'b1, 8'h00, 1'b0, 8'h0A, 8'h08},  // R5 set beats load 0
        '{10'h000, 1'b1, 1'b0, 8'hFF, 1'b1, 8'h00, 8'h08},  // R3 clear reg0
        '{10'h000, 1'b1, 1'b1, 8'hFF, 1'b1, 8'h00, 8'h00},  // R3 clear reg1
        '{10'h000, 1'b1, 1'b0, 8'hFF, 1'b0, 8'h3F, 8'h00},  // R2 unmapped ignored
        '{10'h000, 1'b1, 1'b1, 8'hFF, 1'b0, 8'h3F, 8'h3C},  // R2 reg1 mapping
        '{10'h000, 1'b1, 1'b0, 8'h3F, 1'b1, 8'h00, 8'h3C},  // R3
        '{10'h000, 1'b1, 1'b1, 8'h3C, 1'b1, 8'h00, 8'h00}   // R3
    };

    function automatic string row_tag(int r);
        case (r)
            0, 1:          return "R1";
            2, 11, 12:     return "R2";
            5, 6:          return "R4";
            7, 8:          return "R5";
            default:       return "R3";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Advance one clock and drop the pulse inputs at the following negedge.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        trig     = '0;
        wr_en    = 1'b0;
        dma_done = '0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic sw_write(input logic a, input logic [7:0] d, input logic m);
        wr_en = 1'b1; wr_addr = a; wr_data = d; rst_only = m;
        cyc();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] r0, r1;
        rst_n = 1'b0; trig = '0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
        rd_addr = 1'b0; rst_only = 1'b1; src_en = '0; grp_lvl = '0;
        route = '0; dma_done = '0; cpu_ie = 1'b0; cpu_lvl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10: set flags, then reset again and expect everything cleared.
        trig = 10'h3FF; cyc();
        rst_n = 1'b0; repeat (2) @(posedge clk); @(negedge clk); rst_n = 1'b1;
        rd(1'b0, r0); rd(1'b1, r1);
        chk("R10 reg0 after reset", r0, 8'h00);
        chk("R10 reg1 after reset", r1, 8'h00);
        chk("R10 irq after reset", irq, 1'b0);
        chk("R10 dma_req after reset", dma_req, 10'h000);

        // Table walk: flag sets, write conventions, mapping and overlaps.
        for (int r = 0; r < 15; r++) begin
            trig = TBL[r].trg; wr_en = TBL[r].we; wr_addr = TBL[r].wa;
            wr_data = TBL[r].wd; rst_only = TBL[r].mode;
            cyc();
            rd(1'b0, r0); rd(1'b1, r1);
            chk($sformatf("%s row %0d reg0", row_tag(r), r), r0, TBL[r].e0);
            chk($sformatf("%s row %0d reg1", row_tag(r), r), r1, TBL[r].e1);
            chk($sformatf("R1 row %0d irq with enables off", r), irq, 1'b0);
        end

        // R6: enable gating and strict level comparison.
        src_en = 10'h004; grp_lvl = {3'd0, 3'd0, 3'd3}; cpu_ie = 1'b1; cpu_lvl = 3'd2;
        trig = 10'h004; cyc(); #1;
        chk("R6 irq raised", irq, 1'b1);
        chk("R6 irq id", irq_id, 4'd2);
        chk("R6 irq level", irq_lvl, 3'd3);
        cpu_lvl = 3'd3; #1;
        chk("R6 equal level blocks", irq, 1'b0);
        chk("R7 id zero when idle", irq_id, 4'd0);
        cpu_lvl = 3'd2; cpu_ie = 1'b0; #1;
        chk("R6 global enable off", irq, 1'b0);
        cpu_ie = 1'b1; src_en = 10'h000; #1;
        chk("R6 source enable off", irq, 1'b0);
        src_en = 10'h004; #1;
        chk("R6 re-enabled", irq, 1'b1);

        // R7: level ordering and lowest-index tie break.
        src_en = 10'h106; grp_lvl = {3'd5, 3'd0, 3'd3};
        trig = 10'h102; cyc(); #1;
        chk("R7 highest level id", irq_id, 4'd8);
        chk("R7 highest level value", irq_lvl, 3'd5);
        grp_lvl = {3'd3, 3'd0, 3'd3}; #1;
        chk("R7 tie goes to lowest index", irq_id, 4'd1);

        // R9: request persists without a clear, then follows software clears.
        repeat (3) cyc();
        chk("R9 request persists", irq, 1'b1);
        chk("R9 id persists", irq_id, 4'd1);
        sw_write(1'b0, 8'h02, 1'b1); #1;
        chk("R9 next source after clear", irq_id, 4'd2);
        sw_write(1'b0, 8'h3F, 1'b1); #1;
        chk("R9 all cleared", irq, 1'b0);

        // R8: DMA-routed source waits for completion before the CPU sees it.
        src_en = 10'h020; route = 10'h020; grp_lvl = {3'd0, 3'd6, 3'd0}; cpu_lvl = 3'd0;
        trig = 10'h020; cyc(); #1;
        chk("R8 dma request raised", dma_req, 10'h020);
        chk("R8 no cpu request while pending", irq, 1'b0);
        repeat (3) cyc(); #1;
        chk("R8 still waiting", irq, 1'b0);
        dma_done = 10'h020; cyc(); #1;
        chk("R8 dma request dropped", dma_req, 10'h000);
        chk("R8 cpu request after done", irq, 1'b1);
        chk("R8 id after done", irq_id, 4'd5);
        chk("R8 level after done", irq_lvl, 3'd6);
        sw_write(1'b1, 8'h08, 1'b1); #1;
        chk("R8 cleared flag drops request", irq, 1'b0);
        rd(1'b1, r1);
        chk("R8 flag cleared", r1, 8'h00);

        summary();
        $finish;
    end
endmodule